// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, made of a segment number and an offset, into a physical address. It keeps a small on-chip map of segment descriptors. Each descriptor holds a base (the first physical address of the segment), a limit (the segment length), a valid flag and three permission flags: read, write and execute. A segment-count register says how many descriptors the running program may use. Privileged software loads descriptors and the count through dedicated write ports.

A request carries a segment number, an offset and an access type. One clock later the block gives one of two results. Either it pulses `done` with the physical address, which is the base plus the offset, or it pulses `fault` with a 2-bit cause code. The faults are checked in a fixed order: segment out of range, then invalid descriptor, then offset past the limit, then missing permission. Only the first failing check is reported.

A small state machine sequences the result. It has three states: `XS_IDLE`, `XS_DONE` and `XS_FAULT`. On every clock edge the next state comes from the request alone:
- with no request, any state goes to `XS_IDLE`;
- a request that passes every check goes to `XS_DONE`;
- a request that fails a check goes to `XS_FAULT`.

`done` is high only in `XS_DONE`, and `fault` only in `XS_FAULT`. Back-to-back requests therefore move directly from one result state to the next.

Top module: `seg_xlat`

## Requirements
- R1: After reset, `done` and `fault` are low, the segment count is 0 and every descriptor is invalid. A later request with the count raised but without loading a descriptor reports the invalid-descriptor fault.
- R2: A request whose segment number is greater than or equal to the segment count faults with cause 0.
- R3: A request to an in-range descriptor whose valid flag is 0 faults with cause 1.
- R4: A request whose offset is greater than or equal to the descriptor limit faults with cause 2. An offset of limit minus one is accepted.
- R5: Permission flag bit 0 allows read, bit 1 allows write and bit 2 allows execute. The access codes are 0 for read, 1 for write and 2 for execute. Code 3 never has permission. A request whose access is not allowed faults with cause 3.
- R6: When several checks fail, the cause reported is the first one that fails, in the order range, valid, limit, permission.
- R7: A request that passes all checks makes `done` high for exactly the following cycle. In that cycle `phys_addr` equals base plus offset, modulo 2^24.
- R8: A faulting request makes `fault` high for exactly the following cycle, with `done` low and `phys_addr` at 0.
- R9: A descriptor or count write is seen by requests from the next cycle onward. A request in the same cycle as a write uses the contents from before that write.
- R10: A cycle with no request is followed by a cycle with both `done` and `fault` low.
- R11: Requests on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| req_seg | input | 3 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| cnt_we | input | 1 | Load the segment-count register |
| cnt_wdata | input | 4 | New segment count |
| map_we | input | 1 | Write one descriptor |
| map_idx | input | 3 | Descriptor index to write |
| map_base | input | 24 | Base physical address |
| map_limit | input | 16 | Segment length |
| map_valid | input | 1 | Valid flag |
| map_perm | input | 3 | Permission flags {execute, write, read} |
| done | output | 1 | Translation succeeded (one-cycle pulse) |
| phys_addr | output | 24 | Physical address, 0 unless `done` |
| fault | output | 1 | Translation failed (one-cycle pulse) |
| fault_cause | output | 2 | 0 range, 1 invalid, 2 limit, 3 permission |

## Verification
The assertions assume that `rst_n` is low at time zero and that inputs change only away from the rising edge. They also assume that a write index always names an existing descriptor, which the 3-bit index does by construction. The random stimulus writes descriptors and counts only through the ports, and it keeps the count in the range 0 to 8. Offsets are drawn both uniformly and near each descriptor's limit, so that the limit edge and the priority order are hit often. Same-cycle write-and-request and back-to-back requests are added as directed cases.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_t;

    typedef enum logic [1:0] {
        FC_RANGE   = 2'd0,
        FC_INVALID = 2'd1,
        FC_LIMIT   = 2'd2,
        FC_PERM    = 2'd3
    } fcause_t;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_DONE,
        XS_FAULT
    } xl_state_t;

    localparam int PERM_W = 3;
    localparam int PERM_R = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_X = 2;

endpackage

// File: rtl/seg_map_store.sv
module seg_map_store
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEGS = 8,
    parameter int OFF_W    = 16,
    parameter int BASE_W   = 24,
    localparam int IW      = $clog2(NUM_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [BASE_W-1:0] wbase,
    input  logic [OFF_W-1:0]  wlimit,
    input  logic              wvalid,
    input  logic [PERM_W-1:0] wperm,
    input  logic [IW-1:0]     ridx,
    output logic [BASE_W-1:0] rbase,
    output logic [OFF_W-1:0]  rlimit,
    output logic              rvalid,
    output logic [PERM_W-1:0] rperm
);

    logic [BASE_W-1:0] base_q  [NUM_SEGS];
    logic [OFF_W-1:0]  limit_q [NUM_SEGS];
    logic [PERM_W-1:0] perm_q  [NUM_SEGS];
    logic [NUM_SEGS-1:0] valid_q;

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                perm_q[g]  <= '0;
                valid_q[g] <= 1'b0;
            end else if (we && widx == IW'(g)) begin
                base_q[g]  <= wbase;
                limit_q[g] <= wlimit;
                perm_q[g]  <= wperm;
                valid_q[g] <= wvalid;
            end
        end
    end

    assign rbase  = base_q[ridx];
    assign rlimit = limit_q[ridx];
    assign rvalid = valid_q[ridx];
    assign rperm  = perm_q[ridx];

    // R9
    desc_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (valid_q[$past(widx)] == $past(wvalid)) && (base_q[$past(widx)] == $past(wbase)));

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEGS = 8,
    parameter int OFF_W    = 16,
    parameter int BASE_W   = 24,
    localparam int IW      = $clog2(NUM_SEGS),
    localparam int CW      = $clog2(NUM_SEGS + 1)
) (
    input  logic [CW-1:0]     seg_count,
    input  logic [IW-1:0]     seg,
    input  logic [OFF_W-1:0]  off,
    input  acc_t              acc,
    input  logic [BASE_W-1:0] e_base,
    input  logic [OFF_W-1:0]  e_limit,
    input  logic              e_valid,
    input  logic [PERM_W-1:0] e_perm,
    output logic              bad,
    output fcause_t           cause,
    output logic [BASE_W-1:0] paddr
);

    logic perm_ok;

    always_comb begin
        unique case (acc)
            ACC_RD:  perm_ok = e_perm[PERM_R];
            ACC_WR:  perm_ok = e_perm[PERM_WR];
            ACC_EX:  perm_ok = e_perm[PERM_X];
            default: perm_ok = 1'b0;
        endcase
    end

    always_comb begin
        bad   = 1'b1;
        cause = FC_RANGE;
        if (CW'(seg) >= seg_count) begin
            cause = FC_RANGE;
        end else if (!e_valid) begin
            cause = FC_INVALID;
        end else if (off >= e_limit) begin
            cause = FC_LIMIT;
        end else if (!perm_ok) begin
            cause = FC_PERM;
        end else begin
            bad = 1'b0;
        end
    end

    assign paddr = e_base + BASE_W'(off);

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEGS = 8,
    parameter int OFF_W    = 16,
    parameter int BASE_W   = 24,
    localparam int IW      = $clog2(NUM_SEGS),
    localparam int CW      = $clog2(NUM_SEGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IW-1:0]     req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    input  logic              cnt_we,
    input  logic [CW-1:0]     cnt_wdata,
    input  logic              map_we,
    input  logic [IW-1:0]     map_idx,
    input  logic [BASE_W-1:0] map_base,
    input  logic [OFF_W-1:0]  map_limit,
    input  logic              map_valid,
    input  logic [PERM_W-1:0] map_perm,
    output logic              done,
    output logic [BASE_W-1:0] phys_addr,
    output logic              fault,
    output logic [1:0]        fault_cause
);

    xl_state_t         state_q;
    logic [CW-1:0]     seg_count_q;
    logic [BASE_W-1:0] e_base;
    logic [OFF_W-1:0]  e_limit;
    logic              e_valid;
    logic [PERM_W-1:0] e_perm;
    logic              chk_bad;
    fcause_t           chk_cause;
    logic [BASE_W-1:0] chk_paddr;
    logic [BASE_W-1:0] paddr_q;
    fcause_t           cause_q;

    seg_map_store #(.NUM_SEGS(NUM_SEGS), .OFF_W(OFF_W), .BASE_W(BASE_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .we(map_we), .widx(map_idx), .wbase(map_base), .wlimit(map_limit),
        .wvalid(map_valid), .wperm(map_perm),
        .ridx(req_seg),
        .rbase(e_base), .rlimit(e_limit), .rvalid(e_valid), .rperm(e_perm)
    );

    seg_check #(.NUM_SEGS(NUM_SEGS), .OFF_W(OFF_W), .BASE_W(BASE_W)) i_check (
        .seg_count(seg_count_q), .seg(req_seg), .off(req_off), .acc(acc_t'(req_acc)),
        .e_base(e_base), .e_limit(e_limit), .e_valid(e_valid), .e_perm(e_perm),
        .bad(chk_bad), .cause(chk_cause), .paddr(chk_paddr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      seg_count_q <= '0;
        else if (cnt_we) seg_count_q <= cnt_wdata;
    end

    // State register: the next state depends only on the current request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         state_q <= XS_IDLE;
        else if (!req_valid) state_q <= XS_IDLE;
        else if (chk_bad)   state_q <= XS_FAULT;
        else                state_q <= XS_DONE;
    end

    // Result registers that travel with the state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q <= '0;
            cause_q <= FC_RANGE;
        end else begin
            paddr_q <= (req_valid && !chk_bad) ? chk_paddr : '0;
            cause_q <= (req_valid && chk_bad) ? chk_cause : FC_RANGE;
        end
    end

    always_comb begin
        unique case (state_q)
            XS_DONE:  begin done = 1'b1; fault = 1'b0; end
            XS_FAULT: begin done = 1'b0; fault = 1'b1; end
            default:  begin done = 1'b0; fault = 1'b0; end
        endcase
    end

    assign phys_addr   = paddr_q;
    assign fault_cause = cause_q;

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && !fault));

    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (done != fault));

    // R8
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (phys_addr == '0 && !done));

    // R2
    range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && CW'(req_seg) >= seg_count_q) |=> (fault && fault_cause == FC_RANGE));

endmodule

// File: tb/test_seg_xlat.sv
module test_seg_xlat;

    localparam int N  = 8;
    localparam int IW = 3;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic        cnt_we = 1'b0;
    logic [3:0]  cnt_wdata = '0;
    logic        map_we = 1'b0;
    logic [2:0]  map_idx = '0;
    logic [23:0] map_base = '0;
    logic [15:0] map_limit = '0;
    logic        map_valid = 1'b0;
    logic [2:0]  map_perm = '0;
    logic        done;
    logic [23:0] phys_addr;
    logic        fault;
    logic [1:0]  fault_cause;

    int n_checks = 0;
    int n_fails  = 0;

    logic [23:0] m_base  [N];
    logic [15:0] m_limit [N];
    logic        m_valid [N];
    logic [2:0]  m_perm  [N];
    logic [3:0]  m_count;

    always #4 clk = ~clk;

    seg_xlat i_seg_xlat (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .map_we(map_we), .map_idx(map_idx), .map_base(map_base), .map_limit(map_limit),
        .map_valid(map_valid), .map_perm(map_perm), .done(done), .phys_addr(phys_addr),
        .fault(fault), .fault_cause(fault_cause)
    );

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic void expect_of(input logic [2:0] s, input logic [15:0] o, input logic [1:0] a,
                                      output logic f, output logic [1:0] c, output logic [23:0] p);
        logic ok;
        ok = (a == 2'd0) ? m_perm[s][0] : (a == 2'd1) ? m_perm[s][1] : (a == 2'd2) ? m_perm[s][2] : 1'b0;
        f = 1'b1; c = 2'd0; p = 24'd0;
        if ({1'b0, s} >= m_count)      c = 2'd0;
        else if (!m_valid[s])          c = 2'd1;
        else if (o >= m_limit[s])      c = 2'd2;
        else if (!ok)                  c = 2'd3;
        else begin
            f = 1'b0;
            p = m_base[s] + {8'd0, o};
        end
    endfunction

    task automatic check_result(input string tag, input logic ef, input logic [1:0] ec, input logic [23:0] ep);
        check(tag, "done", {31'd0, done}, {31'd0, !ef});
        check(tag, "fault", {31'd0, fault}, {31'd0, ef});
        if (ef) check(tag, "cause", {30'd0, fault_cause}, {30'd0, ec});
        check(tag, "phys_addr", {8'd0, phys_addr}, {8'd0, ep});
    endtask

    task automatic write_entry(input logic [2:0] idx, input logic [23:0] b, input logic [15:0] l,
                               input logic v, input logic [2:0] pm);
        map_we = 1'b1; map_idx = idx; map_base = b; map_limit = l; map_valid = v; map_perm = pm;
        @(negedge clk);
        map_we = 1'b0;
        m_base[idx] = b; m_limit[idx] = l; m_valid[idx] = v; m_perm[idx] = pm;
    endtask

    task automatic set_count(input logic [3:0] c);
        cnt_we = 1'b1; cnt_wdata = c;
        @(negedge clk);
        cnt_we = 1'b0;
        m_count = c;
    endtask

    task automatic do_req(input string tag, input logic [2:0] s, input logic [15:0] o, input logic [1:0] a);
        logic ef; logic [1:0] ec; logic [23:0] ep;
        expect_of(s, o, a, ef, ec, ep);
        req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
        @(negedge clk);
        req_valid = 1'b0;
        check_result(tag, ef, ec, ep);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic ef; logic [1:0] ec; logic [23:0] ep;
        logic ef2; logic [1:0] ec2; logic [23:0] ep2;
        int unused_seed;
        unused_seed = $urandom(32'h5eed);
        for (int i = 0; i < N; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 1'b0; m_perm[i] = '0;
        end
        m_count = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "done", {31'd0, done}, 32'd0);
        check("R1", "fault", {31'd0, fault}, 32'd0);
        do_req("R1", 3'd0, 16'd0, 2'd0);
        set_count(4'd8);
        do_req("R1", 3'd5, 16'd0, 2'd0);

        // R10: idle cycle after a result
        @(negedge clk);
        check("R10", "done", {31'd0, done}, 32'd0);
        check("R10", "fault", {31'd0, fault}, 32'd0);

        // R7: plain success and wrap
        write_entry(3'd2, 24'h001000, 16'h0100, 1'b1, 3'b111);
        do_req("R7", 3'd2, 16'h0040, 2'd0);
        write_entry(3'd7, 24'hFFFF00, 16'hFFFF, 1'b1, 3'b001);
        do_req("R7", 3'd7, 16'h0200, 2'd0);

        // R4: limit edge
        do_req("R4", 3'd2, 16'h00FF, 2'd1);
        do_req("R4", 3'd2, 16'h0100, 2'd1);

        // R5: permissions
        write_entry(3'd3, 24'h200000, 16'h1000, 1'b1, 3'b010);
        do_req("R5", 3'd3, 16'h0010, 2'd0);
        do_req("R5", 3'd3, 16'h0010, 2'd1);
        do_req("R5", 3'd3, 16'h0010, 2'd2);
        do_req("R5", 3'd2, 16'h0010, 2'd3);

        // R3: invalid entry
        write_entry(3'd4, 24'h300000, 16'h1000, 1'b0, 3'b111);
        do_req("R3", 3'd4, 16'h0001, 2'd0);

        // R2 and R6: range beats everything, invalid beats limit, limit beats perm
        set_count(4'd4);
        do_req("R2", 3'd4, 16'hFFFF, 2'd3);
        do_req("R2", 3'd7, 16'h0000, 2'd0);
        set_count(4'd8);
        do_req("R6", 3'd4, 16'hFFFF, 2'd3);
        do_req("R6", 3'd3, 16'hFFFF, 2'd0);

        // R9: same-cycle write and request sees old contents
        expect_of(3'd2, 16'h0010, 2'd0, ef, ec, ep);
        req_valid = 1'b1; req_seg = 3'd2; req_off = 16'h0010; req_acc = 2'd0;
        map_we = 1'b1; map_idx = 3'd2; map_base = 24'h00ABC0; map_limit = 16'h0008;
        map_valid = 1'b1; map_perm = 3'b001;
        @(negedge clk);
        req_valid = 1'b0; map_we = 1'b0;
        check_result("R9", ef, ec, ep);
        m_base[2] = 24'h00ABC0; m_limit[2] = 16'h0008; m_valid[2] = 1'b1; m_perm[2] = 3'b001;
        do_req("R9", 3'd2, 16'h0010, 2'd0);
        do_req("R9", 3'd2, 16'h0007, 2'd0);

        // R11: back-to-back requests
        expect_of(3'd2, 16'h0003, 2'd0, ef, ec, ep);
        expect_of(3'd3, 16'h0003, 2'd0, ef2, ec2, ep2);
        req_valid = 1'b1; req_seg = 3'd2; req_off = 16'h0003; req_acc = 2'd0;
        @(negedge clk);
        req_seg = 3'd3;
        check_result("R11", ef, ec, ep);
        @(negedge clk);
        req_valid = 1'b0;
        check_result("R11", ef2, ec2, ep2);

        // R8: random mix of writes, counts and requests
        for (int k = 0; k < 600; k++) begin
            int sel;
            sel = int'($urandom % 10);
            if (sel == 0) begin
                write_entry(3'($urandom % 8), 24'($urandom), 16'($urandom % 4096),
                            1'($urandom % 4 != 0), 3'($urandom % 8));
            end else if (sel == 1) begin
                set_count(4'($urandom % 9));
            end else begin
                logic [2:0] s; logic [15:0] o;
                s = 3'($urandom % 8);
                if ($urandom % 2 == 0) o = m_limit[s] + 16'($urandom % 3) - 16'd1;
                else                   o = 16'($urandom % 4096);
                do_req("R8", s, o, 2'($urandom % 4));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule